// File: doc/BRIEF.md
# Full-Map Directory Coherence Controller

This block is the home node for a small group of memory blocks that K caching nodes share. For each block it holds a sharer vector with one bit per node, an exclusive-ownership (dirty) flag and the memory copy of the data. Read requests and write (read-exclusive) requests arrive on one request port. Where caches must be contacted, the block issues invalidations or recalls on a command port. It collects acknowledgements and recalled data on a reply port, and it answers each requester on a response port with data, an exclusive grant or a negative acknowledgement (NACK).

While a block waits on caches it is held in a transient busy state. Any other request to that block in that time gets a NACK, and the requester must retry. Other blocks keep being served. A writer gets its grant only once every invalidated sharer has acknowledged, so the write looks atomic to all nodes. Invalidations to several sharers leave one per cycle, without waiting for earlier acknowledgements. Replies are always accepted, so a stalled request stream cannot stop transactions from completing.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is clean, has no sharers and holds its own block index as data. An owned (dirty) block always has exactly one sharer bit set. Inputs are accepted and no command or response is pending.
- R2: A read of a clean block is answered on the next cycle with the memory data, nack=0 and excl=0, and the reader is added to the sharers.
- R3: A read of a block owned by another node sends one command of kind 1 (recall, keep shared) to the owner. The owner's data reply is written to memory and the block becomes clean with sharers {owner, reader}. The reader then gets the recalled data with excl=0.
- R4: A write to a clean block with other sharers sends one command of kind 0 (invalidate) to each sharer except the writer, in ascending node order. While cmd_ready_i is high these go out on consecutive cycles.
- R5: The write response is withheld until an acknowledgement has come back from every invalidated sharer. It then carries excl=1 and the memory data, and the block becomes dirty with only the writer as sharer.
- R6: A write to a clean block with no sharer other than the writer is granted on the next cycle with excl=1, and no command is sent.
- R7: A write to a block owned by another node sends kind 2 (recall and invalidate) to the owner. The recalled data goes to memory, ownership passes to the writer, and the writer gets that data with excl=1.
- R8: A request to a busy block gets a NACK on the next cycle (nack=1, excl=0, node = requester) and changes nothing. Requests to other blocks are served normally.
- R9: A request from the current owner of a dirty block is granted on the next cycle with excl=1, and no command is sent.
- R10: rpl_ready_o is always high. A reply is ignored unless its block is waiting on that node. An ignored reply changes no data and no sharer bits.
- R11: A response stays valid and stable until rsp_ready_i is high. While it waits, req_ready_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted |
| req_write_i | input | 1 | 1 = write (exclusive), 0 = read |
| req_node_i | input | NODE_W | Requesting node |
| req_blk_i | input | BLK_W | Requested block |
| cmd_valid_o | output | 1 | Command to a cache valid |
| cmd_ready_i | input | 1 | Command taken by the network |
| cmd_kind_o | output | 2 | 0 invalidate, 1 recall keep shared, 2 recall and invalidate |
| cmd_node_o | output | NODE_W | Target node |
| cmd_blk_o | output | BLK_W | Target block |
| rpl_valid_i | input | 1 | Cache reply valid |
| rpl_ready_o | output | 1 | Reply accepted (always high) |
| rpl_node_i | input | NODE_W | Replying node |
| rpl_blk_i | input | BLK_W | Block the reply concerns |
| rpl_data_i | input | DATA_W | Recalled data (ignored for acks) |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_node_o | output | NODE_W | Node the response is for |
| rsp_blk_o | output | BLK_W | Block of the response |
| rsp_nack_o | output | 1 | Request refused, retry |
| rsp_excl_o | output | 1 | Exclusive ownership granted |
| rsp_data_o | output | DATA_W | Block data |

## Verification
The bench uses the defaults NODES=4, BLOCKS=4, DATA_W=8. With these values every one of the 16 sharer patterns can be built and combined with each of the 4 writers. Each pass checks the exact ascending invalidation order, the held-back grant, a NACK on a collision, and the recall that follows. Block data starts at the block index and recalled data is a different value, so it is visible whether memory was updated or left alone. Directed cases cover a recall that moves ownership, a read by the owner itself, stray replies, response back-pressure and traffic to two blocks at once.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    CMD_INV     = 2'd0,
    CMD_RCL_SHR = 2'd1,
    CMD_RCL_INV = 2'd2
  } cmd_kind_e;

  typedef enum logic [1:0] {
    BLK_IDLE,
    BLK_INV,
    BLK_RCL,
    BLK_DONE
  } blk_state_e;
endpackage

// File: rtl/dir_lsb_pick.sv
module dir_lsb_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  oh_o
);
  // lowest set bit wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    oh_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o    = 1'b1;
        idx_o    = IW'(i);
        oh_o     = '0;
        oh_o[i]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dir_block.sv
module dir_block
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT = '0,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int CNT_W = $clog2(NODES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_go_i,
  input  logic              req_wr_i,
  input  logic [NODE_W-1:0] req_node_i,
  output logic              imm_o,
  output logic              imm_nack_o,
  output logic              imm_excl_o,
  output logic              cmd_req_o,
  output logic [1:0]        cmd_kind_o,
  output logic [NODE_W-1:0] cmd_node_o,
  input  logic              cmd_go_i,
  input  logic              rpl_go_i,
  input  logic [NODE_W-1:0] rpl_node_i,
  input  logic [DATA_W-1:0] rpl_data_i,
  output logic              done_o,
  output logic [NODE_W-1:0] done_node_o,
  output logic              done_excl_o,
  input  logic              done_take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic [NODES-1:0]  pres_o,
  output logic              dirty_o
);
  blk_state_e        state_q;
  cmd_kind_e         kind_q;
  logic [NODES-1:0]  pres_q, send_q, tgt_q;
  logic              dirty_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NODE_W-1:0] node_q;
  logic [DATA_W-1:0] data_q;

  logic [NODES-1:0]  req_oh, others, cmd_oh, node_oh;
  logic              busy, own_req, waiting, rpl_hit;

  function automatic logic [CNT_W-1:0] popcnt(input logic [NODES-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NODES; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  assign req_oh  = NODES'(1) << req_node_i;
  assign node_oh = NODES'(1) << node_q;
  assign others  = pres_q & ~req_oh;
  assign busy    = (state_q != BLK_IDLE);
  assign own_req = dirty_q && (pres_q == req_oh);
  assign waiting = (state_q == BLK_INV) || (state_q == BLK_RCL);
  assign rpl_hit = rpl_go_i && waiting && tgt_q[rpl_node_i];

  assign imm_o      = busy || own_req || (!dirty_q && (!req_wr_i || others == '0));
  assign imm_nack_o = busy;
  assign imm_excl_o = !busy && (own_req || (!dirty_q && req_wr_i));

  dir_lsb_pick #(.N(NODES)) u_node_pick (
    .vec_i (send_q),
    .any_o (cmd_req_o),
    .idx_o (cmd_node_o),
    .oh_o  (cmd_oh)
  );
  assign cmd_kind_o = kind_q;

  assign done_o      = (state_q == BLK_DONE);
  assign done_node_o = node_q;
  assign done_excl_o = wr_q;
  assign data_o      = data_q;
  assign busy_o      = busy;
  assign pres_o      = pres_q;
  assign dirty_o     = dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BLK_IDLE;
      kind_q  <= CMD_INV;
      pres_q  <= '0;
      send_q  <= '0;
      tgt_q   <= '0;
      dirty_q <= 1'b0;
      wr_q    <= 1'b0;
      cnt_q   <= '0;
      node_q  <= '0;
      data_q  <= INIT;
    end else begin
      if (req_go_i && !busy && !own_req) begin
        if (!dirty_q) begin
          if (!req_wr_i) begin
            pres_q <= pres_q | req_oh;
          end else if (others == '0) begin
            pres_q  <= req_oh;
            dirty_q <= 1'b1;
          end else begin
            state_q <= BLK_INV;
            kind_q  <= CMD_INV;
            send_q  <= others;
            tgt_q   <= others;
            cnt_q   <= popcnt(others);
            node_q  <= req_node_i;
            wr_q    <= 1'b1;
          end
        end else begin
          // owned elsewhere: recall from the single owner
          state_q <= BLK_RCL;
          kind_q  <= req_wr_i ? CMD_RCL_INV : CMD_RCL_SHR;
          send_q  <= pres_q;
          tgt_q   <= pres_q;
          cnt_q   <= CNT_W'(1);
          node_q  <= req_node_i;
          wr_q    <= req_wr_i;
        end
      end
      if (cmd_go_i) send_q <= send_q & ~cmd_oh;
      if (rpl_hit) begin
        tgt_q[rpl_node_i] <= 1'b0;
        cnt_q <= cnt_q - CNT_W'(1);
        if (state_q == BLK_RCL) data_q <= rpl_data_i;
        if (cnt_q == CNT_W'(1)) begin
          state_q <= BLK_DONE;
          if (wr_q) begin
            pres_q  <= node_oh;
            dirty_q <= 1'b1;
          end else begin
            pres_q  <= pres_q | node_oh;
            dirty_q <= 1'b0;
          end
        end
      end
      if (done_take_i) state_q <= BLK_IDLE;
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NODES = 4,
  parameter int BLOCKS = 4,
  parameter int DATA_W = 8,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BLK_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [NODE_W-1:0] req_node_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_kind_o,
  output logic [NODE_W-1:0] cmd_node_o,
  output logic [BLK_W-1:0]  cmd_blk_o,
  input  logic              rpl_valid_i,
  output logic              rpl_ready_o,
  input  logic [NODE_W-1:0] rpl_node_i,
  input  logic [BLK_W-1:0]  rpl_blk_i,
  input  logic [DATA_W-1:0] rpl_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [NODE_W-1:0] rsp_node_o,
  output logic [BLK_W-1:0]  rsp_blk_o,
  output logic              rsp_nack_o,
  output logic              rsp_excl_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic [BLOCKS-1:0] req_go, imm, imm_nack, imm_excl;
  logic [BLOCKS-1:0] cmd_req, cmd_go, rpl_go;
  logic [BLOCKS-1:0] blk_done, done_take, blk_busy, blk_dirty;
  logic [1:0]        cmd_kind  [BLOCKS];
  logic [NODE_W-1:0] cmd_node  [BLOCKS];
  logic [NODE_W-1:0] done_node [BLOCKS];
  logic [BLOCKS-1:0] done_excl;
  logic [DATA_W-1:0] blk_data  [BLOCKS];
  logic [NODES-1:0]  blk_pres  [BLOCKS];
  logic [BLOCKS*NODES-1:0] pres_flat;

  logic              cmd_any, done_any, req_fire;
  logic [BLK_W-1:0]  cmd_idx, done_idx;
  logic [BLOCKS-1:0] cmd_oh, done_oh;

  logic              rsp_valid_q, rsp_nack_q, rsp_excl_q;
  logic [NODE_W-1:0] rsp_node_q;
  logic [BLK_W-1:0]  rsp_blk_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign req_ready_o = !rsp_valid_q && !done_any;
  assign req_fire    = req_valid_i && req_ready_o;
  assign rpl_ready_o = 1'b1;

  for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
    assign req_go[b]    = req_fire && (req_blk_i == BLK_W'(b));
    assign rpl_go[b]    = rpl_valid_i && (rpl_blk_i == BLK_W'(b));
    assign cmd_go[b]    = cmd_oh[b] && cmd_ready_i;
    assign done_take[b] = done_oh[b] && !rsp_valid_q;
    assign pres_flat[b*NODES +: NODES] = blk_pres[b];

    dir_block #(
      .NODES  (NODES),
      .DATA_W (DATA_W),
      .INIT   (DATA_W'(b))
    ) u_blk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_go_i    (req_go[b]),
      .req_wr_i    (req_write_i),
      .req_node_i  (req_node_i),
      .imm_o       (imm[b]),
      .imm_nack_o  (imm_nack[b]),
      .imm_excl_o  (imm_excl[b]),
      .cmd_req_o   (cmd_req[b]),
      .cmd_kind_o  (cmd_kind[b]),
      .cmd_node_o  (cmd_node[b]),
      .cmd_go_i    (cmd_go[b]),
      .rpl_go_i    (rpl_go[b]),
      .rpl_node_i  (rpl_node_i),
      .rpl_data_i  (rpl_data_i),
      .done_o      (blk_done[b]),
      .done_node_o (done_node[b]),
      .done_excl_o (done_excl[b]),
      .done_take_i (done_take[b]),
      .data_o      (blk_data[b]),
      .busy_o      (blk_busy[b]),
      .pres_o      (blk_pres[b]),
      .dirty_o     (blk_dirty[b])
    );
  end

  dir_lsb_pick #(.N(BLOCKS)) u_cmd_pick (
    .vec_i (cmd_req),
    .any_o (cmd_any),
    .idx_o (cmd_idx),
    .oh_o  (cmd_oh)
  );

  dir_lsb_pick #(.N(BLOCKS)) u_done_pick (
    .vec_i (blk_done),
    .any_o (done_any),
    .idx_o (done_idx),
    .oh_o  (done_oh)
  );

  assign cmd_valid_o = cmd_any;
  assign cmd_kind_o  = cmd_kind[cmd_idx];
  assign cmd_node_o  = cmd_node[cmd_idx];
  assign cmd_blk_o   = cmd_idx;

  // single response slot; finished transactions take precedence over new requests
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_nack_q  <= 1'b0;
      rsp_excl_q  <= 1'b0;
      rsp_node_q  <= '0;
      rsp_blk_q   <= '0;
      rsp_data_q  <= '0;
    end else if (rsp_valid_q) begin
      if (rsp_ready_i) rsp_valid_q <= 1'b0;
    end else if (done_any) begin
      rsp_valid_q <= 1'b1;
      rsp_nack_q  <= 1'b0;
      rsp_excl_q  <= done_excl[done_idx];
      rsp_node_q  <= done_node[done_idx];
      rsp_blk_q   <= done_idx;
      rsp_data_q  <= blk_data[done_idx];
    end else if (req_fire && imm[req_blk_i]) begin
      rsp_valid_q <= 1'b1;
      rsp_nack_q  <= imm_nack[req_blk_i];
      rsp_excl_q  <= imm_excl[req_blk_i];
      rsp_node_q  <= req_node_i;
      rsp_blk_q   <= req_blk_i;
      rsp_data_q  <= blk_data[req_blk_i];
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_nack_o  = rsp_nack_q;
  assign rsp_excl_o  = rsp_excl_q;
  assign rsp_node_o  = rsp_node_q;
  assign rsp_blk_o   = rsp_blk_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
  parameter int NODES = 4,
  parameter int BLOCKS = 4,
  parameter int DATA_W = 8,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BLK_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic                    req_ready_o,
  input logic [BLK_W-1:0]        req_blk_i,
  input logic                    cmd_valid_o,
  input logic [BLK_W-1:0]        cmd_blk_o,
  input logic                    rsp_valid_o,
  input logic                    rsp_ready_i,
  input logic [NODE_W-1:0]       rsp_node_o,
  input logic                    rsp_nack_o,
  input logic                    rsp_excl_o,
  input logic [DATA_W-1:0]       rsp_data_o,
  input logic [BLOCKS-1:0]       busy_i,
  input logic [BLOCKS-1:0]       dirty_i,
  input logic [BLOCKS*NODES-1:0] pres_i
);
  assert_rsp_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o)
      && $stable(rsp_node_o) && $stable(rsp_nack_o) && $stable(rsp_excl_o));

  assert_full_stall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  assert_busy_nack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && busy_i[req_blk_i] |=> rsp_valid_o && rsp_nack_o);

  assert_nack_not_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_nack_o |-> !rsp_excl_o);

  assert_cmd_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_i[cmd_blk_o]);

  for (genvar b = 0; b < BLOCKS; b++) begin : g_own
    assert_dirty_owner_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dirty_i[b] |-> $onehot(pres_i[b*NODES +: NODES]));
  end
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(
  .NODES  (NODES),
  .BLOCKS (BLOCKS),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_blk_i   (req_blk_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_blk_o   (cmd_blk_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_node_o  (rsp_node_o),
  .rsp_nack_o  (rsp_nack_o),
  .rsp_excl_o  (rsp_excl_o),
  .rsp_data_o  (rsp_data_o),
  .busy_i      (blk_busy),
  .dirty_i     (blk_dirty),
  .pres_i      (pres_flat)
);

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;
  localparam int K = 4;
  localparam int B = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 0, req_write = 0;
  logic [1:0]    req_node = 0, req_blk = 0;
  logic          req_ready;
  logic          cmd_valid, cmd_ready = 1;
  logic [1:0]    cmd_kind, cmd_node, cmd_blk;
  logic          rpl_valid = 0, rpl_ready;
  logic [1:0]    rpl_node = 0, rpl_blk = 0;
  logic [DW-1:0] rpl_data = 0;
  logic          rsp_valid, rsp_ready = 1, rsp_nack, rsp_excl;
  logic [1:0]    rsp_node, rsp_blk;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int errors = 0;

  dir_home_ctrl #(.NODES(K), .BLOCKS(B), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_node_i(req_node), .req_blk_i(req_blk),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_kind_o(cmd_kind),
    .cmd_node_o(cmd_node), .cmd_blk_o(cmd_blk),
    .rpl_valid_i(rpl_valid), .rpl_ready_o(rpl_ready), .rpl_node_i(rpl_node),
    .rpl_blk_i(rpl_blk), .rpl_data_i(rpl_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_node_o(rsp_node),
    .rsp_blk_o(rsp_blk), .rsp_nack_o(rsp_nack), .rsp_excl_o(rsp_excl),
    .rsp_data_o(rsp_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    summary();
  end

  // all tasks start and end at a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_req(input bit wr, input int node, input int blk);
    req_valid = 1'b1; req_write = wr; req_node = 2'(node); req_blk = 2'(blk);
    for (int i = 0; i < 50 && !req_ready; i++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_rpl(input int node, input int blk, input int data);
    rpl_valid = 1'b1; rpl_node = 2'(node); rpl_blk = 2'(blk); rpl_data = DW'(data);
    @(negedge clk);
    rpl_valid = 1'b0;
  endtask

  // request answered in the cycle after acceptance; exp_data < 0 skips the data check
  task automatic req_imm(input bit wr, input int node, input int blk, input int nack,
                         input int excl, input int exp_data, input string tag);
    send_req(wr, node, blk);
    chk({tag, " imm valid"}, int'(rsp_valid), 1);
    chk({tag, " nack"}, int'(rsp_nack), nack);
    chk({tag, " excl"}, int'(rsp_excl), excl);
    chk({tag, " node"}, int'(rsp_node), node);
    if (exp_data >= 0) chk({tag, " data"}, int'(rsp_data), exp_data);
    @(negedge clk);
  endtask

  task automatic get_rsp(input int node, input int excl, input int exp_data, input string tag);
    for (int i = 0; i < 20; i++) begin
      if (rsp_valid) begin
        chk({tag, " rsp nack"}, int'(rsp_nack), 0);
        chk({tag, " rsp excl"}, int'(rsp_excl), excl);
        chk({tag, " rsp node"}, int'(rsp_node), node);
        chk({tag, " rsp data"}, int'(rsp_data), exp_data);
        @(negedge clk);
        return;
      end
      @(negedge clk);
    end
    chk({tag, " rsp timeout"}, 0, 1);
  endtask

  task automatic expect_cmd(input int kind, input int node, input int blk, input string tag);
    chk({tag, " cmd valid"}, int'(cmd_valid), 1);
    chk({tag, " cmd kind"}, int'(cmd_kind), kind);
    chk({tag, " cmd node"}, int'(cmd_node), node);
    chk({tag, " cmd blk"}, int'(cmd_blk), blk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);

    // sweep: every sharer pattern against every writer
    for (int p = 0; p < 16; p++) begin
      for (int w = 0; w < K; w++) begin
        int blk, oth, last, r, d;
        blk = (p + w) % B;
        oth = p & ~(1 << w);
        last = -1;
        for (int n = 0; n < K; n++) if (oth[n]) last = n;
        do_reset();
        for (int n = 0; n < K; n++)
          if (p[n]) req_imm(1'b0, n, blk, 0, 0, blk, "R2 clean read");
        send_req(1'b1, w, blk);
        if (oth == 0) begin
          chk("R6 imm valid", int'(rsp_valid), 1);
          chk("R6 excl", int'(rsp_excl), 1);
          chk("R6 data", int'(rsp_data), blk);
          chk("R6 no cmd", int'(cmd_valid), 0);
          @(negedge clk);
        end else begin
          chk("R5 held before invals", int'(rsp_valid), 0);
          for (int n = 0; n < K; n++)
            if (oth[n]) expect_cmd(0, n, blk, "R4 inval order");
          chk("R4 no extra cmd", int'(cmd_valid), 0);
          req_imm(1'b0, (w + 1) % K, blk, 1, 0, -1, "R8 collision");
          for (int n = 0; n < K; n++) begin
            if (oth[n]) begin
              send_rpl(n, blk, 0);
              if (n != last) begin
                @(negedge clk);
                chk("R5 held until last ack", int'(rsp_valid), 0);
              end
            end
          end
          get_rsp(w, 1, blk, "R5 grant");
        end
        // block now owned by w; reader r forces a recall
        r = (w + 1) % K;
        d = 8'h40 + p * 4 + w;
        send_req(1'b0, r, blk);
        chk("R3 no early rsp", int'(rsp_valid), 0);
        expect_cmd(1, w, blk, "R3 recall");
        send_rpl(w, blk, d);
        get_rsp(r, 0, d, "R3 recalled data");
        req_imm(1'b0, (w + 2) % K, blk, 0, 0, d, "R3 memory updated");
      end
    end

    // R9 and R7: owner re-reads, then ownership moves by recall-invalidate
    do_reset();
    req_imm(1'b1, 0, 1, 0, 1, 1, "R6 sole writer");
    req_imm(1'b0, 0, 1, 0, 1, 1, "R9 owner read");
    chk("R9 no cmd", int'(cmd_valid), 0);
    send_req(1'b1, 2, 1);
    expect_cmd(2, 0, 1, "R7 recall inval");
    send_rpl(0, 1, 8'h5A);
    get_rsp(2, 1, 8'h5A, "R7 grant");
    send_req(1'b0, 0, 1);
    expect_cmd(1, 2, 1, "R7 new owner");
    send_rpl(2, 1, 8'h66);
    get_rsp(0, 0, 8'h66, "R7 recall from new owner");

    // R10 stray replies
    do_reset();
    chk("R10 rpl_ready", int'(rpl_ready), 1);
    send_rpl(1, 2, 8'hEE);
    chk("R10 no cmd", int'(cmd_valid), 0);
    chk("R10 no rsp", int'(rsp_valid), 0);
    req_imm(1'b0, 3, 2, 0, 0, 2, "R10 data kept");
    req_imm(1'b1, 3, 2, 0, 1, 2, "R10 sharers kept");
    send_req(1'b0, 1, 2);
    expect_cmd(1, 3, 2, "R10 recall");
    send_rpl(2, 2, 8'h11);
    @(negedge clk);
    chk("R10 wrong node ignored", int'(rsp_valid), 0);
    send_rpl(3, 2, 8'h22);
    get_rsp(1, 0, 8'h22, "R10 right node");

    // R11 response back-pressure
    do_reset();
    rsp_ready = 1'b0;
    send_req(1'b0, 1, 3);
    chk("R11 valid", int'(rsp_valid), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 held", int'(rsp_valid), 1);
      chk("R11 data stable", int'(rsp_data), 3);
      chk("R11 req stalled", int'(req_ready), 0);
      chk("R10 rpl_ready while stalled", int'(rpl_ready), 1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 released", int'(rsp_valid), 0);
    @(negedge clk);

    // R8 other blocks proceed while one is busy
    do_reset();
    req_imm(1'b0, 1, 0, 0, 0, 0, "R2 share blk0");
    send_req(1'b1, 2, 0);
    expect_cmd(0, 1, 0, "R4 single inval");
    req_imm(1'b0, 3, 1, 0, 0, 1, "R8 other block served");
    req_imm(1'b1, 3, 0, 1, 0, -1, "R8 busy block nacked");
    send_rpl(1, 0, 0);
    get_rsp(2, 1, 0, "R5 grant after ack");

    summary();
  end
endmodule